// File: doc/BRIEF.md
# Four-Phase Instruction Cycle Generator

This block splits a fast input clock into four phases, Q1 to Q4, that repeat in that order. One pass through the four phases is one instruction cycle of the processor core. The block drives one single-cycle strobe per phase. It also drives enables that pace the core: advancing the program counter, loading the fetched instruction word, reading a data operand and writing back a result. A divided clock runs at one quarter of the input rate for use outside the core, and a cycle-start pulse marks the beginning of each instruction cycle.

All outputs are registered and change on the rising edge of the input clock. A synchronous active-high reset and a hold input both park the generator with every output low. When the generator leaves that idle state, it always starts again at Q1. This keeps instruction cycles whole, even when the core is paused partway through one.

Top module: `quad_phase_gen`

## Requirements
- R1: In the cycle after a clock edge with `rst` high, every output is low.
- R2: `phase` is one-hot or zero. Bit 0 is Q1, bit 1 is Q2, bit 2 is Q3 and bit 3 is Q4. While the generator runs, exactly one bit is high.
- R3: After idle, the first phase is Q1. Phases then follow the order Q1, Q2, Q3, Q4, Q1, with one step per input clock.
- R4: A clock edge with `hold` high (and `rst` low) clears `phase` and all enables in the next cycle. The first edge with `hold` low restarts at Q1, whatever phase was interrupted.
- R5: `pc_step` is high exactly in the cycles where Q1 is active.
- R6: `ir_load` is high exactly in the cycles where Q4 is active.
- R7: `opnd_rd` is high exactly in the cycles where Q2 is active.
- R8: `dest_wr` is high exactly in the cycles where Q4 is active.
- R9: `clk_div4` is high during Q1 and Q2. It is low during Q3, during Q4 and while idle. A free run therefore gives a period of four input clocks.
- R10: `cyc_start` pulses exactly with Q1, so the number of pulses equals the number of instruction cycles started.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Pause: idles the generator; release restarts at Q1 |
| phase | output | 4 | One-hot phase strobes, bit 0 = Q1 ... bit 3 = Q4 |
| pc_step | output | 1 | Program-counter advance enable (Q1) |
| ir_load | output | 1 | Instruction word load enable (Q4) |
| opnd_rd | output | 1 | Data operand read enable (Q2) |
| dest_wr | output | 1 | Destination write enable (Q4) |
| clk_div4 | output | 1 | Divided clock, high in Q1 and Q2 |
| cyc_start | output | 1 | Instruction-cycle start pulse (Q1) |

## Verification
The only state is the phase ring, so a corrupt or skipped state shows on `phase` within one input clock. Because every enable is registered from the same next-phase value, a mismatch also shows on the enables in that same cycle. A ring that fails to restart at Q1 after a hold shows up in the first cycle after release. A divided clock with the wrong duty, or a drifting count of cycle starts, shows up within four input clocks. The reference model is compared with every output on every clock, across resets and holds in every phase.

// File: rtl/qpg_pkg.sv
package qpg_pkg;
  localparam int unsigned QPG_PHASES = 4;
  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } ph_idx_t;
endpackage

// File: rtl/qpg_ring.sv
module qpg_ring #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output logic [N-1:0] ph_q,
  output logic [N-1:0] ph_d
);
  localparam logic [N-1:0] FIRST = {{(N-1){1'b0}}, 1'b1};

  always_comb begin
    if (hold)
      ph_d = '0;
    else if (ph_q == '0)
      ph_d = FIRST;
    else
      ph_d = {ph_q[N-2:0], ph_q[N-1]};
  end

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_d;
  end
endmodule

// File: rtl/qpg_decode.sv
module qpg_decode #(
  parameter int unsigned N      = 4,
  parameter int unsigned PC_IX  = 0,
  parameter int unsigned RD_IX  = 1,
  parameter int unsigned WR_IX  = 3,
  parameter int unsigned LD_IX  = 3,
  parameter int unsigned HI_CNT = N / 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ph_d,
  output logic         pc_step,
  output logic         ir_load,
  output logic         opnd_rd,
  output logic         dest_wr,
  output logic         clk_div4,
  output logic         cyc_start
);
  logic [HI_CNT-1:0] hi_bits;

  genvar g;
  generate
    for (g = 0; g < HI_CNT; g++) begin : g_hi
      assign hi_bits[g] = ph_d[g];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_step   <= 1'b0;
      ir_load   <= 1'b0;
      opnd_rd   <= 1'b0;
      dest_wr   <= 1'b0;
      clk_div4  <= 1'b0;
      cyc_start <= 1'b0;
    end else begin
      pc_step   <= ph_d[PC_IX];
      ir_load   <= ph_d[LD_IX];
      opnd_rd   <= ph_d[RD_IX];
      dest_wr   <= ph_d[WR_IX];
      clk_div4  <= |hi_bits;
      cyc_start <= ph_d[0];
    end
  end
endmodule

// File: rtl/quad_phase_gen.sv
module quad_phase_gen
  import qpg_pkg::*;
#(
  parameter int unsigned N = QPG_PHASES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  output logic [N-1:0] phase,
  output logic         pc_step,
  output logic         ir_load,
  output logic         opnd_rd,
  output logic         dest_wr,
  output logic         clk_div4,
  output logic         cyc_start
);
  localparam int unsigned PC_IX = int'(PH_Q1);
  localparam int unsigned RD_IX = int'(PH_Q2);
  localparam int unsigned WR_IX = int'(PH_Q4);

  logic [N-1:0] ph_next;

  qpg_ring #(.N(N)) u_ring (
    .clk  (clk),
    .rst  (rst),
    .hold (hold),
    .ph_q (phase),
    .ph_d (ph_next)
  );

  qpg_decode #(
    .N      (N),
    .PC_IX  (PC_IX),
    .RD_IX  (RD_IX),
    .WR_IX  (WR_IX),
    .LD_IX  (WR_IX),
    .HI_CNT (N / 2)
  ) u_dec (
    .clk       (clk),
    .rst       (rst),
    .ph_d      (ph_next),
    .pc_step   (pc_step),
    .ir_load   (ir_load),
    .opnd_rd   (opnd_rd),
    .dest_wr   (dest_wr),
    .clk_div4  (clk_div4),
    .cyc_start (cyc_start)
  );
endmodule

// File: rtl/quad_phase_gen_chk.sv
module quad_phase_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       hold,
  input logic [3:0] phase,
  input logic       pc_step,
  input logic       ir_load,
  input logic       opnd_rd,
  input logic       dest_wr,
  input logic       clk_div4,
  input logic       cyc_start
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (phase == 4'b0 && !clk_div4 && !cyc_start));
  // R2
  one_hot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(phase));
  // R3
  order_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !hold && phase != 4'b0) |=> (phase == {$past(phase[2:0]), $past(phase[3])}));
  // R3
  start_q1_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !hold && phase == 4'b0) |=> phase[0]);
  // R4
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    hold |=> (phase == 4'b0 && !pc_step && !ir_load && !opnd_rd && !dest_wr));
  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (rst) pc_step == phase[0]);
  // R6
  ir_load_chk: assert property (@(posedge clk) disable iff (rst) ir_load == phase[3]);
  // R7
  opnd_rd_chk: assert property (@(posedge clk) disable iff (rst) opnd_rd == phase[1]);
  // R8
  dest_wr_chk: assert property (@(posedge clk) disable iff (rst) dest_wr == phase[3]);
  // R9
  clk_div4_chk: assert property (@(posedge clk) disable iff (rst) clk_div4 == (phase[0] | phase[1]));
  // R10
  cyc_start_chk: assert property (@(posedge clk) disable iff (rst) cyc_start == phase[0]);
endmodule

bind quad_phase_gen quad_phase_gen_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hold      (hold),
  .phase     (phase),
  .pc_step   (pc_step),
  .ir_load   (ir_load),
  .opnd_rd   (opnd_rd),
  .dest_wr   (dest_wr),
  .clk_div4  (clk_div4),
  .cyc_start (cyc_start)
);

// File: tb/quad_phase_gen_test.sv
module quad_phase_gen_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hold = 1'b0;
  logic [3:0] phase;
  logic       pc_step, ir_load, opnd_rd, dest_wr, clk_div4, cyc_start;

  int tests = 0;
  int fails = 0;
  int mph = -1;          // model phase: -1 idle, 0..3 = Q1..Q4
  int exp_cyc = 0;
  int got_cyc = 0;
  bit started = 0;
  bit done = 0;
  string ctx = "R1";

  always #4 clk = ~clk;  // 125 MHz

  quad_phase_gen uut (
    .clk(clk), .rst(rst), .hold(hold), .phase(phase),
    .pc_step(pc_step), .ir_load(ir_load), .opnd_rd(opnd_rd),
    .dest_wr(dest_wr), .clk_div4(clk_div4), .cyc_start(cyc_start)
  );

  // behavioural reference model
  always @(posedge clk) begin
    started <= 1'b1;
    if (rst) begin
      mph <= -1; ctx <= "R1";
    end else if (hold) begin
      mph <= -1; ctx <= "R4";
    end else begin
      if (mph < 0) begin
        mph <= 0; ctx <= "R3"; exp_cyc <= exp_cyc + 1;
      end else begin
        mph <= (mph + 1) % 4; ctx <= "R2";
        if (mph == 3) exp_cyc <= exp_cyc + 1;
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      chk({ctx, " phase"}, int'(phase), (mph < 0) ? 0 : (1 << mph));
      chk("R5 pc_step",   int'(pc_step),   int'(mph == 0));
      chk("R6 ir_load",   int'(ir_load),   int'(mph == 3));
      chk("R7 opnd_rd",   int'(opnd_rd),   int'(mph == 1));
      chk("R8 dest_wr",   int'(dest_wr),   int'(mph == 3));
      chk("R9 clk_div4",  int'(clk_div4),  int'(mph == 0 || mph == 1));
      chk("R10 cyc_start", int'(cyc_start), int'(mph == 0));
      if (cyc_start === 1'b1) got_cyc++;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(21);
    // single-cycle hold in each phase position
    for (int k = 0; k < 4; k++) begin
      hold = 1'b1; step(1);
      hold = 1'b0; step(5 + k);
    end
    // long hold
    hold = 1'b1; step(6);
    hold = 1'b0; step(10);
    // reset mid-cycle, then reset with hold
    step(2); rst = 1'b1; step(1); rst = 1'b0; step(7);
    rst = 1'b1; hold = 1'b1; step(2); rst = 1'b0; step(2); hold = 1'b0;
    step(203);
    // R10: count of cycle-start pulses against model count
    tests++;
    if (got_cyc != exp_cyc) begin
      fails++;
      $display("FAIL R10 cycle count actual=%0d expected=%0d", got_cyc, exp_cyc);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule